// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block is a small level-one data cache placed between one requester and a slower backing store that moves whole lines. The requester presents word reads and word writes. Each request gets either an immediate acknowledge, when the word is resident, or a wait response. The requester keeps the request steady until the acknowledge comes. Storage is direct-mapped: every line slot holds one tag, a valid flag and a dirty flag. Writes stay in the cache until the line is evicted (write-back). A write that misses first brings the line in (write-allocate).

A miss is resolved as a sequence of single transactions on the line port. When the resident line is dirty, it is written out first. The requested line is then read in. Each transaction ends with a one-cycle completion pulse from the backing store. The controller keeps reporting wait during that completion cycle as well. The request is only served on the cycle after the final refill completes, when it hits.

The requester address is wider than the cache's 10-bit word space. Only its low ten bits are used, so an out-of-range or negative (two's complement) address lands on its non-negative remainder modulo 1024.

Top module: `wb_cache_ctrl`

## Requirements
- R1: The 10-bit word address splits into word offset bits [1:0], slot index bits [6:2] and tag bits [9:7]. For example, 0b0100111011 gives tag 2, index 14 and offset 3. The line port address is the 8-bit value {tag, index}, with the word offset dropped.
- R2: After reset every slot is invalid. The first access to any address misses, including an address whose tag field is zero.
- R3: A read that hits asserts rsp_ok in the same cycle the request is presented, with the addressed word on rsp_rdata. No line transaction is active while rsp_ok is high.
- R4: A write hit replaces only the addressed word and marks the line dirty. A later eviction of that line carries the written value.
- R5: A miss whose slot is clean or invalid issues exactly one line read at {new tag, index}. The tag is recorded only on completion. The request is acknowledged five cycles after it is first presented, and the cycle right after the refill completes is a hit.
- R6: A miss whose slot is dirty first writes the stored line to {old tag, index} and clears the dirty flag on completion. It then refills as in R5, and is acknowledged ten cycles after first presentation. The cycle after the write-back completes is still a wait.
- R7: rsp_ok is low in every cycle in which mem_done is high.
- R8: A write miss refills the line and then writes the word. The other three words of that line keep their backing-store values.
- R9: Only req_addr[9:0] is used. A 16-bit value of -10 (0xFFF6) addresses word 1014, and 1049 (0x0419) addresses word 25.
- R10: At most one line transaction is outstanding. mem_valid, mem_write and mem_line_addr stay unchanged from assertion until the cycle of mem_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until rsp_ok |
| req_write | input | 1 | 1 = word write, 0 = word read |
| req_addr | input | 16 | Word address; low 10 bits used |
| req_wdata | input | 32 | Write word |
| rsp_ok | output | 1 | Request served this cycle (low = wait) |
| rsp_rdata | output | 32 | Read word, valid with rsp_ok on reads |
| mem_valid | output | 1 | Line transaction active |
| mem_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_line_addr | output | 8 | Line address {tag, index} |
| mem_wdata | output | 128 | Line being written back, word 0 in the low bits |
| mem_done | input | 1 | One-cycle completion of the active transaction |
| mem_rdata | input | 128 | Line read data, valid with mem_done |

## Verification
The critical overlap is between completion of a line transaction and the requester response. In that cycle the slot state changes on the coming edge, but the response must still be wait. This overlap is provoked with clean misses, dirty misses and write misses against a backing-store model with a fixed three-cycle latency. At every sampled cycle, the bench checks that mem_done and rsp_ok are never high together. It also counts wait cycles per request and compares them against the expected 0, 5 or 10. Every write-back line is compared with a shadow copy of the last stored words.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    WBC_IDLE  = 2'd0,
    WBC_EVICT = 2'd1,
    WBC_FILL  = 2'd2
  } wbc_state_e;
endpackage

// File: rtl/wbc_addr_split.sv
module wbc_addr_split #(
  parameter int REQ_W  = 16,
  parameter int ADDR_W = 10,
  parameter int OFS_W  = 2,
  parameter int IDX_W  = 5,
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
  input  logic [REQ_W-1:0] req_addr,
  output logic [TAG_W-1:0] tag,
  output logic [IDX_W-1:0] idx,
  output logic [OFS_W-1:0] ofs
);
  logic [ADDR_W-1:0] wrapped;
  logic              unused_hi;

  // modulo-2^ADDR_W wrap: two's complement truncation keeps the remainder
  assign wrapped   = req_addr[ADDR_W-1:0];
  assign unused_hi = ^req_addr[REQ_W-1:ADDR_W];
  assign ofs = wrapped[OFS_W-1:0];
  assign idx = wrapped[OFS_W +: IDX_W];
  assign tag = wrapped[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int SETS  = 32,
  parameter int TAG_W = 3,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_set,
  input  logic             dirty_clr,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag
);
  logic [SETS-1:0]  valid_q, valid_d;
  logic [SETS-1:0]  dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel;
    assign sel = (idx == IDX_W'(s));

    always_comb begin
      valid_d[s] = valid_q[s];
      dirty_d[s] = dirty_q[s];
      if (sel && fill_en) valid_d[s] = 1'b1;
      if (sel && dirty_set)                   dirty_d[s] = 1'b1;
      else if (sel && (dirty_clr || fill_en)) dirty_d[s] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (sel && fill_en) tag_q[s] <= fill_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int SETS       = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFS_W  = $clog2(LINE_WORDS),
  localparam int LINE_W = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              line_we,
  input  logic [LINE_W-1:0] line_wdata,
  input  logic              word_we,
  input  logic [WORD_W-1:0] word_wdata,
  output logic [LINE_W-1:0] rd_line,
  output logic [WORD_W-1:0] rd_word
);
  logic [LINE_W-1:0] lines_q [SETS];
  logic [LINE_W-1:0] merged;
  logic [WORD_W-1:0] words [LINE_WORDS];

  assign rd_line = lines_q[idx];

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    assign words[w] = rd_line[w*WORD_W +: WORD_W];
    assign merged[w*WORD_W +: WORD_W] =
      line_we                  ? line_wdata[w*WORD_W +: WORD_W] :
      (ofs == OFS_W'(w))       ? word_wdata : words[w];
  end

  assign rd_word = words[ofs];

  for (genvar s = 0; s < SETS; s++) begin : g_line
    logic wen;
    assign wen = (idx == IDX_W'(s)) && (line_we || word_we);
    always_ff @(posedge clk) begin
      if (wen) lines_q[s] <= merged;
    end
  end
endmodule

// File: rtl/wbc_miss_ctrl.sv
module wbc_miss_ctrl
  import wbc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hit,
  input  logic victim_dirty,
  input  logic mem_done,
  output logic idle,
  output logic mem_valid,
  output logic mem_write,
  output logic fill_en,
  output logic dirty_clr
);
  wbc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WBC_IDLE:  if (req_valid && !hit) state_d = victim_dirty ? WBC_EVICT : WBC_FILL;
      WBC_EVICT: if (mem_done) state_d = WBC_IDLE;
      WBC_FILL:  if (mem_done) state_d = WBC_IDLE;
      default:   state_d = WBC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WBC_IDLE;
    else        state_q <= state_d;
  end

  assign idle      = (state_q == WBC_IDLE);
  assign mem_valid = !idle;
  assign mem_write = (state_q == WBC_EVICT);
  assign fill_en   = (state_q == WBC_FILL)  && mem_done;
  assign dirty_clr = (state_q == WBC_EVICT) && mem_done;
endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl #(
  parameter int REQ_W      = 16,
  parameter int ADDR_W     = 10,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 32,
  localparam int OFS_W   = $clog2(LINE_WORDS),
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - IDX_W - OFS_W,
  localparam int LINE_W  = WORD_W * LINE_WORDS,
  localparam int LADDR_W = TAG_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [REQ_W-1:0]   req_addr,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic               rsp_ok,
  output logic [WORD_W-1:0]  rsp_rdata,
  output logic               mem_valid,
  output logic               mem_write,
  output logic [LADDR_W-1:0] mem_line_addr,
  output logic [LINE_W-1:0]  mem_wdata,
  input  logic               mem_done,
  input  logic [LINE_W-1:0]  mem_rdata
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [TAG_W-1:0] req_tag, slot_tag;
  logic [IDX_W-1:0] req_idx;
  logic [OFS_W-1:0] req_ofs;
  logic             slot_valid, slot_dirty, hit, idle;
  logic             fill_en, dirty_clr, word_we;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wbc_addr_split #(.REQ_W(REQ_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_split (
    .req_addr (req_addr),
    .tag      (req_tag),
    .idx      (req_idx),
    .ofs      (req_ofs)
  );

  assign hit     = req_valid && slot_valid && (slot_tag == req_tag);
  assign rsp_ok  = hit && idle;
  assign word_we = rsp_ok && req_write;

  wbc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .idx       (req_idx),
    .fill_en   (fill_en),
    .fill_tag  (req_tag),
    .dirty_set (word_we),
    .dirty_clr (dirty_clr),
    .rd_valid  (slot_valid),
    .rd_dirty  (slot_dirty),
    .rd_tag    (slot_tag)
  );

  wbc_data_store #(.SETS(SETS), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_data (
    .clk        (clk),
    .idx        (req_idx),
    .ofs        (req_ofs),
    .line_we    (fill_en),
    .line_wdata (mem_rdata),
    .word_we    (word_we),
    .word_wdata (req_wdata),
    .rd_line    (mem_wdata),
    .rd_word    (rsp_rdata)
  );

  wbc_miss_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .req_valid    (req_valid),
    .hit          (hit),
    .victim_dirty (slot_valid && slot_dirty),
    .mem_done     (mem_done),
    .idle         (idle),
    .mem_valid    (mem_valid),
    .mem_write    (mem_write),
    .fill_en      (fill_en),
    .dirty_clr    (dirty_clr)
  );

  assign mem_line_addr = mem_write ? {slot_tag, req_idx} : {req_tag, req_idx};
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int LADDR_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               rsp_ok,
  input logic               mem_valid,
  input logic               mem_write,
  input logic [LADDR_W-1:0] mem_line_addr,
  input logic               mem_done
);
  // R3
  ok_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> (req_valid && !mem_valid));

  // R7
  done_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_done |-> !rsp_ok);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_done) |=> (mem_valid && $stable(mem_write) && $stable(mem_line_addr)));

  // R6
  evict_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_done && mem_write) |=> (!rsp_ok && !mem_valid));

  // R5
  fill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_done && !mem_write && req_valid) |=> rsp_ok);
endmodule

bind wb_cache_ctrl wbc_checker #(.LADDR_W(LADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .rsp_ok        (rsp_ok),
  .mem_valid     (mem_valid),
  .mem_write     (mem_write),
  .mem_line_addr (mem_line_addr),
  .mem_done      (mem_done)
);

// File: tb/wb_cache_ctrl_tb.sv
module wb_cache_ctrl_tb;
  localparam int LAT = 3;
  localparam int NV  = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [15:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_ok;
  logic [31:0]  rsp_rdata;
  logic         mem_valid, mem_write;
  logic [7:0]   mem_line_addr;
  logic [127:0] mem_wdata;
  logic         mem_done = 1'b0;
  logic [127:0] mem_rdata = '0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [127:0] bmem [256];
  logic [31:0]  shadow [1024];
  logic [7:0]   last_wb = '0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  wb_cache_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_line_addr(mem_line_addr),
    .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit good, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {write, addr16, wdata, expected read, expected waits}
  localparam logic [88:0] VEC [NV] = '{
    {1'b0, 16'h003B, 32'h0,        32'hC0DE003B, 8'd5},   // R2 R5 cold miss
    {1'b0, 16'h0038, 32'h0,        32'hC0DE0038, 8'd0},   // R3 hit
    {1'b1, 16'h0039, 32'h11111111, 32'h0,        8'd0},   // R4 write hit
    {1'b0, 16'h0039, 32'h0,        32'h11111111, 8'd0},   // R4 readback
    {1'b0, 16'h013B, 32'h0,        32'hC0DE013B, 8'd10},  // R1 R6 dirty victim
    {1'b0, 16'h003A, 32'h0,        32'hC0DE003A, 8'd5},   // R5 clean victim
    {1'b0, 16'h0039, 32'h0,        32'h11111111, 8'd0},   // R6 written-back word returns
    {1'b1, 16'h02C5, 32'h22222222, 32'h0,        8'd5},   // R8 write miss
    {1'b0, 16'h02C4, 32'h0,        32'hC0DE02C4, 8'd0},   // R8 neighbour kept
    {1'b0, 16'h02C5, 32'h0,        32'h22222222, 8'd0},   // R8 written word
    {1'b0, 16'hFFF6, 32'h0,        32'hC0DE03F6, 8'd5},   // R9 negative wraps
    {1'b0, 16'h0419, 32'h0,        32'hC0DE0019, 8'd5},   // R9 over-range wraps
    {1'b0, 16'h03F6, 32'h0,        32'hC0DE03F6, 8'd0}    // R9 alias hits
  };

  // backing store: fixed latency, one-cycle done pulse
  always @(posedge clk) begin
    if (mem_done) begin
      mem_done <= 1'b0;
      m_cnt = 0;
    end else if (mem_valid) begin
      if (m_cnt == LAT - 1) begin
        mem_done <= 1'b1;
        m_cnt = 0;
        if (mem_write) begin
          bmem[mem_line_addr] <= mem_wdata;
          last_wb <= mem_line_addr;
          chk(mem_wdata == {shadow[{mem_line_addr, 2'd3}], shadow[{mem_line_addr, 2'd2}],
                            shadow[{mem_line_addr, 2'd1}], shadow[{mem_line_addr, 2'd0}]},
              "R4 write-back data", mem_wdata,
              {shadow[{mem_line_addr, 2'd3}], shadow[{mem_line_addr, 2'd2}],
               shadow[{mem_line_addr, 2'd1}], shadow[{mem_line_addr, 2'd0}]});
        end else begin
          mem_rdata <= bmem[mem_line_addr];
        end
      end else begin
        m_cnt++;
      end
    end
  end

  task automatic access(input bit wr, input logic [15:0] a, input logic [31:0] wd,
                        input logic [31:0] exp, input int exp_waits, input string req);
    int waits = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    #1;
    for (;;) begin
      if (mem_done) chk(!rsp_ok, "R7 wait on completion", 128'(rsp_ok), 128'd0);
      if (rsp_ok || waits > 60) break;
      @(negedge clk); #1;
      waits++;
    end
    chk(waits == exp_waits, {req, " wait count"}, 128'(waits), 128'(exp_waits));
    if (!wr) chk(rsp_rdata == exp, {req, " read data"}, 128'(rsp_rdata), 128'(exp));
    else shadow[a[9:0]] = wd;
  endtask

  initial begin
    for (int l = 0; l < 256; l++)
      for (int j = 0; j < 4; j++) bmem[l][j*32 +: 32] = 32'hC0DE0000 | 32'({l[7:0], j[1:0]});
    for (int w = 0; w < 1024; w++) shadow[w] = 32'hC0DE0000 | 32'(w);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!rsp_ok, "R2 reset rsp_ok", 128'(rsp_ok), 128'd0);
    chk(!mem_valid, "R2 reset mem_valid", 128'(mem_valid), 128'd0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][88], VEC[i][87:72], VEC[i][71:40], VEC[i][39:8], int'(VEC[i][7:0]),
             $sformatf("R%0s vec%0d", "5", i));
      if (i == 4) chk(last_wb == 8'h0E, "R1 write-back line address", 128'(last_wb), 128'h0E);
    end

    // R6 dirty write-miss line evicted by another tag in the same slot
    access(1'b0, 16'h00C4, 32'h0, 32'hC0DE00C4, 10, "R6 second eviction");
    chk(last_wb == 8'hB1, "R6 old-tag address", 128'(last_wb), 128'hB1);

    // R2 reset invalidates all slots
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!rsp_ok && !mem_valid, "R2 in reset quiet", 128'({rsp_ok, mem_valid}), 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b0, 16'h0039, 32'h0, 32'h11111111, 5, "R2 miss after reset");
    access(1'b0, 16'h02C5, 32'h0, 32'h22222222, 5, "R2 second miss after reset");

    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule